// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Sequencer

This block sits beside the execute stage of a small in-order core. Each cycle it looks at three sources of control flow change. The first is the set of synchronous exception flags raised for the instruction now in execute. The second is an interrupt (or non-maskable interrupt) that an external arbiter has already accepted. The third is a return-from-trap strobe. At most one of them is acted on. On a trap the block records the trap cause and the faulting or interrupted program counter, and saves and clears the global interrupt enable. It then hands the fetch stage a new program counter. On a return it restores the interrupt enable and sends fetch back to the saved program counter.

A three-state machine sequences this work. In state RUN the block accepts requests. Transition RUN→TRAP_REDIR fires when an interrupt accept or an enabled exception is seen. Transition RUN→RET_REDIR fires on a return strobe with no trap pending. Both redirect states present the new program counter for exactly one cycle, then go back to RUN. While they do, every request and every software register write belongs to a squashed instruction and is dropped. Software writes to the status and saved-PC registers arrive on plain write ports.

Top module: `trap_seq`

## Requirements
- R1: While reset is held and right after it, `mstatus_o`, `mepc_o` and `mcause_o` read 0 and `redir_valid_o` and `squash_o` are 0.
- R2: Exception flag bit i has priority over every higher bit. The codes by bit are: bit0 fetch access fault 1, bit1 fetch parity/checksum fault 49, bit2 fetch bus fault 48, bit3 illegal instruction 2, bit4 user ECALL 8, bit5 machine ECALL 11, bit6 breakpoint 3, bit7 store access fault 7, bit8 load access fault 5. Exceptions cannot be masked. The winning code goes to `mcause_o` with bit 31 cleared.
- R3: Exception flags are ignored when `ex_valid_i` is 0, because execution of that instruction is not attempted. In that case there is no squash, no redirect and no register change.
- R4: A trap or return accepted in RUN at clock edge k drives `redir_valid_o` high for exactly the cycle after edge k, then low. For exceptions `redir_pc_o` is `tvec_i` with bits [1:0] cleared, whatever the mode bits hold.
- R5: On any trap entry, `mepc_o` becomes `ex_pc_i` with bit 0 cleared, MPIE (bit 7) takes the old MIE (bit 3), and MIE is cleared. This applies to NMIs as well.
- R6: An interrupt accept wins over any simultaneous exception. `mcause_o` becomes bit 31 set with `irq_code_i` in bits [10:0], and `redir_pc_o` is `irq_target_i`.
- R7: A return redirects to the current `mepc_o`, sets MIE from MPIE and sets MPIE to 1. `mepc_o` and `mcause_o` are left unchanged.
- R8: If a trap and a return are requested in the same cycle, the trap is taken and the return is dropped.
- R9: `squash_o` is 1 combinationally in RUN in any cycle where a trap is accepted, so the instruction in execute is not committed. Otherwise it is 0.
- R10: During either redirect state, exception flags, interrupt accepts, return strobes and software writes have no effect. The registers hold their values and no second redirect follows.
- R11: A software write to mstatus keeps only MIE (bit 3) and MPIE (bit 7); all other bits read 0. A write to mepc clears bit 0. A software write in the same cycle as a trap or return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_valid_i | input | 1 | Instruction in execute is attempting execution |
| ex_pc_i | input | 32 | Program counter of the instruction in execute |
| exc_flags_i | input | 9 | Synchronous exception flags, bit order as in R2 |
| irq_take_i | input | 1 | Arbiter has accepted an interrupt or NMI |
| irq_code_i | input | 11 | Cause code of the accepted interrupt |
| irq_target_i | input | 32 | Handler address of the accepted interrupt |
| mret_i | input | 1 | Return-from-trap strobe |
| tvec_i | input | 32 | Trap vector register (base plus mode bits) |
| mstatus_we_i | input | 1 | Software write strobe for mstatus |
| mstatus_wdata_i | input | 32 | Software write data for mstatus |
| mepc_we_i | input | 1 | Software write strobe for mepc |
| mepc_wdata_i | input | 32 | Software write data for mepc |
| mstatus_o | output | 32 | Status register (MIE bit 3, MPIE bit 7) |
| mepc_o | output | 32 | Saved exception program counter |
| mcause_o | output | 32 | Trap cause (interrupt flag bit 31) |
| squash_o | output | 1 | Instruction in execute must not commit |
| redir_valid_o | output | 1 | Fetch redirect is valid this cycle |
| redir_pc_o | output | 32 | Fetch redirect target |

## Verification
The assertions check several rules on every cycle. A redirect lasts exactly one cycle. Every squash is followed by a redirect. Trap entry saves MIE into MPIE and clears MIE. A return restores MIE and targets the saved PC. An interrupt accept yields an interrupt cause and its own target. The registers stay frozen during a redirect, and an idle cycle changes nothing. Only the bench's scenarios can show the rest. The 511-way sweep of exception flag patterns shows the full priority order and the code values. Pairing interrupts with exceptions shows which one wins, and pairing traps with returns shows that the trap wins. Other scenarios show the masking of software register bits and the dropping of writes that collide with a trap.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int NEXC      = 9;
    localparam int MIE_BIT   = 3;
    localparam int MPIE_BIT  = 7;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_TRAP_REDIR = 2'd1,
        ST_RET_REDIR  = 2'd2
    } seq_state_e;

    // Cause code for the flag at position idx; position is priority rank.
    function automatic logic [5:0] exc_code(input int idx);
        logic [5:0] c;
        case (idx)
            0:       c = 6'd1;   // fetch access fault
            1:       c = 6'd49;  // fetch parity/checksum fault
            2:       c = 6'd48;  // fetch bus fault
            3:       c = 6'd2;   // illegal instruction
            4:       c = 6'd8;   // ECALL from user mode
            5:       c = 6'd11;  // ECALL from machine mode
            6:       c = 6'd3;   // breakpoint
            7:       c = 6'd7;   // store access fault
            8:       c = 6'd5;   // load access fault
            default: c = 6'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/trap_exc_prio.sv
module trap_exc_prio #(
    parameter int N      = trap_pkg::NEXC,
    parameter int CODE_W = 11
) (
    input  logic [N-1:0]      flags_i,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o,
    output logic [N-1:0]      grant_o
);

    // Lowest flag position wins: each grant masked by all lower flags.
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_grant
            if (gi == 0) begin : g_first
                assign grant_o[gi] = flags_i[gi];
            end else begin : g_rest
                assign grant_o[gi] = flags_i[gi] & ~(|flags_i[gi-1:0]);
            end
        end
    endgenerate

    assign any_o = |flags_i;

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) begin
                code_o = code_o | CODE_W'(trap_pkg::exc_code(i));
            end
        end
    end

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid_i,
    input  logic [XLEN-1:0]   ex_pc_i,
    input  logic              exc_any_i,
    input  logic [CODE_W-1:0] exc_cd_i,
    input  logic              irq_take_i,
    input  logic [CODE_W-1:0] irq_code_i,
    input  logic [XLEN-1:0]   irq_target_i,
    input  logic              mret_i,
    input  logic [XLEN-1:0]   tvec_i,
    input  logic [XLEN-1:0]   mepc_q_i,
    output logic              enter_o,
    output logic              ret_o,
    output logic              sw_ok_o,
    output logic [XLEN-1:0]   cause_w_o,
    output logic [XLEN-1:0]   epc_w_o,
    output logic              squash_o,
    output logic              redir_valid_o,
    output logic [XLEN-1:0]   redir_pc_o
);

    localparam int PAD_W = XLEN - 1 - CODE_W;
    localparam logic [XLEN-1:0] TVEC_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] PC_MASK   = ~XLEN'(1);

    trap_pkg::seq_state_e state_q, state_d;
    logic [XLEN-1:0]      redir_pc_q, redir_pc_d;

    logic take_irq, take_exc;

    assign take_irq = irq_take_i;
    assign take_exc = ex_valid_i & exc_any_i & ~irq_take_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= trap_pkg::ST_RUN;
            redir_pc_q <= '0;
        end else begin
            state_q    <= state_d;
            redir_pc_q <= redir_pc_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d       = state_q;
        redir_pc_d    = redir_pc_q;
        enter_o       = 1'b0;
        ret_o         = 1'b0;
        sw_ok_o       = 1'b0;
        squash_o      = 1'b0;
        redir_valid_o = 1'b0;
        cause_w_o     = '0;
        epc_w_o       = ex_pc_i & PC_MASK;
        unique case (state_q)
            trap_pkg::ST_RUN: begin
                if (take_irq) begin
                    enter_o    = 1'b1;
                    squash_o   = 1'b1;
                    cause_w_o  = {1'b1, {PAD_W{1'b0}}, irq_code_i};
                    redir_pc_d = irq_target_i;
                    state_d    = trap_pkg::ST_TRAP_REDIR;
                end else if (take_exc) begin
                    enter_o    = 1'b1;
                    squash_o   = 1'b1;
                    cause_w_o  = {1'b0, {PAD_W{1'b0}}, exc_cd_i};
                    redir_pc_d = tvec_i & TVEC_MASK;
                    state_d    = trap_pkg::ST_TRAP_REDIR;
                end else if (mret_i) begin
                    ret_o      = 1'b1;
                    redir_pc_d = mepc_q_i;
                    state_d    = trap_pkg::ST_RET_REDIR;
                end else begin
                    sw_ok_o    = 1'b1;
                end
            end
            trap_pkg::ST_TRAP_REDIR: begin
                redir_valid_o = 1'b1;
                state_d       = trap_pkg::ST_RUN;
            end
            trap_pkg::ST_RET_REDIR: begin
                redir_valid_o = 1'b1;
                state_d       = trap_pkg::ST_RUN;
            end
            default: begin
                state_d = trap_pkg::ST_RUN;
            end
        endcase
    end

    assign redir_pc_o = redir_pc_q;

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_i,
    input  logic [XLEN-1:0] cause_w_i,
    input  logic [XLEN-1:0] epc_w_i,
    input  logic            ret_i,
    input  logic            sw_ok_i,
    input  logic            mstatus_we_i,
    input  logic [XLEN-1:0] mstatus_wdata_i,
    input  logic            mepc_we_i,
    input  logic [XLEN-1:0] mepc_wdata_i,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o
);

    localparam logic [XLEN-1:0] PC_MASK = ~XLEN'(1);

    logic            mie_q, mpie_q;
    logic [XLEN-1:0] mepc_q, mcause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie_q    <= 1'b0;
            mpie_q   <= 1'b0;
            mepc_q   <= '0;
            mcause_q <= '0;
        end else if (enter_i) begin
            mpie_q   <= mie_q;
            mie_q    <= 1'b0;
            mepc_q   <= epc_w_i;
            mcause_q <= cause_w_i;
        end else if (ret_i) begin
            mie_q    <= mpie_q;
            mpie_q   <= 1'b1;
        end else if (sw_ok_i) begin
            if (mstatus_we_i) begin
                mie_q  <= mstatus_wdata_i[trap_pkg::MIE_BIT];
                mpie_q <= mstatus_wdata_i[trap_pkg::MPIE_BIT];
            end
            if (mepc_we_i) begin
                mepc_q <= mepc_wdata_i & PC_MASK;
            end
        end
    end

    always_comb begin
        mstatus_o                     = '0;
        mstatus_o[trap_pkg::MIE_BIT]  = mie_q;
        mstatus_o[trap_pkg::MPIE_BIT] = mpie_q;
    end

    assign mepc_o   = mepc_q;
    assign mcause_o = mcause_q;

endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 11,
    parameter int NEXC   = trap_pkg::NEXC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid_i,
    input  logic [XLEN-1:0]   ex_pc_i,
    input  logic [NEXC-1:0]   exc_flags_i,
    input  logic              irq_take_i,
    input  logic [CODE_W-1:0] irq_code_i,
    input  logic [XLEN-1:0]   irq_target_i,
    input  logic              mret_i,
    input  logic [XLEN-1:0]   tvec_i,
    input  logic              mstatus_we_i,
    input  logic [XLEN-1:0]   mstatus_wdata_i,
    input  logic              mepc_we_i,
    input  logic [XLEN-1:0]   mepc_wdata_i,
    output logic [XLEN-1:0]   mstatus_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic              squash_o,
    output logic              redir_valid_o,
    output logic [XLEN-1:0]   redir_pc_o
);

    logic              exc_any;
    logic [CODE_W-1:0] exc_cd;
    logic [NEXC-1:0]   exc_grant;
    logic              enter, ret, sw_ok;
    logic [XLEN-1:0]   cause_w, epc_w;

    trap_exc_prio #(.N(NEXC), .CODE_W(CODE_W)) u_prio (
        .flags_i (exc_flags_i),
        .any_o   (exc_any),
        .code_o  (exc_cd),
        .grant_o (exc_grant)
    );

    trap_seq_fsm #(.XLEN(XLEN), .CODE_W(CODE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ex_valid_i    (ex_valid_i),
        .ex_pc_i       (ex_pc_i),
        .exc_any_i     (exc_any),
        .exc_cd_i      (exc_cd),
        .irq_take_i    (irq_take_i),
        .irq_code_i    (irq_code_i),
        .irq_target_i  (irq_target_i),
        .mret_i        (mret_i),
        .tvec_i        (tvec_i),
        .mepc_q_i      (mepc_o),
        .enter_o       (enter),
        .ret_o         (ret),
        .sw_ok_o       (sw_ok),
        .cause_w_o     (cause_w),
        .epc_w_o       (epc_w),
        .squash_o      (squash_o),
        .redir_valid_o (redir_valid_o),
        .redir_pc_o    (redir_pc_o)
    );

    trap_csr_file #(.XLEN(XLEN)) u_csr (
        .clk             (clk),
        .rst_n           (rst_n),
        .enter_i         (enter),
        .cause_w_i       (cause_w),
        .epc_w_i         (epc_w),
        .ret_i           (ret),
        .sw_ok_i         (sw_ok),
        .mstatus_we_i    (mstatus_we_i),
        .mstatus_wdata_i (mstatus_wdata_i),
        .mepc_we_i       (mepc_we_i),
        .mepc_wdata_i    (mepc_wdata_i),
        .mstatus_o       (mstatus_o),
        .mepc_o          (mepc_o),
        .mcause_o        (mcause_o)
    );

    // Grant vector is one-hot by construction; exposed for the checker.
    logic grant_onehot;
    assign grant_onehot = $onehot0(exc_grant);

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
    parameter int XLEN   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_valid_i,
    input logic            irq_take_i,
    input logic [XLEN-1:0] irq_target_i,
    input logic            mret_i,
    input logic            mstatus_we_i,
    input logic            mepc_we_i,
    input logic [XLEN-1:0] mstatus_o,
    input logic [XLEN-1:0] mepc_o,
    input logic [XLEN-1:0] mcause_o,
    input logic            squash_o,
    input logic            redir_valid_o,
    input logic [XLEN-1:0] redir_pc_o
);

    // R4
    redir_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |=> !redir_valid_o);

    // R9
    squash_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> redir_valid_o);

    // R5
    entry_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> (!mstatus_o[3] && (mstatus_o[7] == $past(mstatus_o[3]))));

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && irq_take_i) |=>
            (mcause_o[XLEN-1] && (redir_pc_o == $past(irq_target_i))));

    // R7
    mret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && mret_i && !squash_o) |=>
            ((mstatus_o[3] == $past(mstatus_o[7])) && mstatus_o[7]
             && (redir_pc_o == $past(mepc_o)) && $stable(mcause_o)));

    // R10
    redir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |=> ($stable(mepc_o) && $stable(mcause_o) && $stable(mstatus_o)));

    // R3
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && !ex_valid_i && !irq_take_i && !mret_i
         && !mstatus_we_i && !mepc_we_i) |=>
            (!redir_valid_o && $stable(mcause_o) && $stable(mepc_o) && $stable(mstatus_o)));

endmodule

bind trap_seq trap_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ex_valid_i    (ex_valid_i),
    .irq_take_i    (irq_take_i),
    .irq_target_i  (irq_target_i),
    .mret_i        (mret_i),
    .mstatus_we_i  (mstatus_we_i),
    .mepc_we_i     (mepc_we_i),
    .mstatus_o     (mstatus_o),
    .mepc_o        (mepc_o),
    .mcause_o      (mcause_o),
    .squash_o      (squash_o),
    .redir_valid_o (redir_valid_o),
    .redir_pc_o    (redir_pc_o)
);

// File: tb/sim_trap_seq.sv
module sim_trap_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid_i = 1'b0;
    logic [31:0] ex_pc_i = '0;
    logic [8:0]  exc_flags_i = '0;
    logic        irq_take_i = 1'b0;
    logic [10:0] irq_code_i = '0;
    logic [31:0] irq_target_i = '0;
    logic        mret_i = 1'b0;
    logic [31:0] tvec_i = '0;
    logic        mstatus_we_i = 1'b0;
    logic [31:0] mstatus_wdata_i = '0;
    logic        mepc_we_i = 1'b0;
    logic [31:0] mepc_wdata_i = '0;
    logic [31:0] mstatus_o, mepc_o, mcause_o, redir_pc_o;
    logic        squash_o, redir_valid_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    trap_seq u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ex_valid_i = 0; exc_flags_i = '0; irq_take_i = 0; mret_i = 0;
        mstatus_we_i = 0; mepc_we_i = 0;
    endtask

    function automatic logic [31:0] bcode(input int b);
        case (b)
            0: return 1;  1: return 49; 2: return 48; 3: return 2;
            4: return 8;  5: return 11; 6: return 3;  7: return 7;
            default: return 5;
        endcase
    endfunction

    task automatic set_mstatus(input logic [31:0] v);
        mstatus_we_i = 1; mstatus_wdata_i = v; tick(); mstatus_we_i = 0;
    endtask

    initial begin
        logic [31:0] pc, tv, saved_pc, saved_cause, saved_st;
        @(negedge clk);
        // R1 reset
        chk("R1 mstatus", mstatus_o, 0);
        chk("R1 mepc", mepc_o, 0);
        chk("R1 mcause", mcause_o, 0);
        chk("R1 redir", {31'd0, redir_valid_o}, 0);
        tick();
        rst_n = 1;
        tick();
        chk("R1 after release", {31'd0, squash_o}, 0);

        // R2/R4/R5/R9 sweep over every nonzero flag pattern
        for (int m = 1; m < 512; m++) begin
            int low;
            logic mie;
            mie = m[0] ^ m[4];
            set_mstatus(mie ? 32'h8 : 32'h0);
            pc = 32'h2000 + m * 6 + 1;
            tv = 32'h8000_0000 + m * 128 + (m % 4);
            low = 0;
            for (int b = 8; b >= 0; b--) if (m[b]) low = b;
            ex_valid_i = 1; exc_flags_i = m[8:0]; ex_pc_i = pc; tvec_i = tv;
            #1 chk("R9 squash", {31'd0, squash_o}, 1);
            tick(); idle();
            chk("R4 valid", {31'd0, redir_valid_o}, 1);
            chk("R4 target", redir_pc_o, tv & ~32'h3);
            chk("R2 cause", mcause_o, bcode(low));
            chk("R5 mepc", mepc_o, pc & ~32'h1);
            chk("R5 mstatus", mstatus_o, mie ? 32'h80 : 32'h0);
            tick();
            chk("R4 one cycle", {31'd0, redir_valid_o}, 0);
        end

        // R3 flags without execution attempt
        saved_cause = mcause_o; saved_pc = mepc_o;
        set_mstatus(32'h8);
        ex_valid_i = 0; exc_flags_i = 9'h1FF; ex_pc_i = 32'h7770;
        #1 chk("R3 no squash", {31'd0, squash_o}, 0);
        tick(); idle();
        chk("R3 no redirect", {31'd0, redir_valid_o}, 0);
        chk("R3 cause held", mcause_o, saved_cause);
        chk("R3 mepc held", mepc_o, saved_pc);
        chk("R3 mstatus held", mstatus_o, 32'h8);

        // R6 interrupt accepts, with and without competing exceptions
        for (int k = 0; k < 23; k++) begin
            logic [10:0] code;
            code = (k == 0) ? 11'd3 : (k == 1) ? 11'd7 : (k == 2) ? 11'd11 :
                   (k < 19) ? 11'(k + 13) : 11'(1024 + k - 19);
            set_mstatus(k[0] ? 32'h8 : 32'h80);
            pc = 32'h3000 + k * 4;
            ex_valid_i = 1; exc_flags_i = k[1] ? 9'h1FF : 9'h0; ex_pc_i = pc;
            irq_take_i = 1; irq_code_i = code; irq_target_i = 32'h4000_0000 + code * 4;
            tvec_i = 32'h9000_0000;
            #1 chk("R9 irq squash", {31'd0, squash_o}, 1);
            tick(); idle();
            chk("R6 cause", mcause_o, 32'h8000_0000 | 32'(code));
            chk("R6 target", redir_pc_o, 32'h4000_0000 + code * 4);
            chk("R5 irq mepc", mepc_o, pc);
            chk("R5 irq mstatus", mstatus_o, k[0] ? 32'h80 : 32'h0);
            tick();
        end

        // R7 return with MPIE=1 and MPIE=0
        for (int r = 0; r < 2; r++) begin
            saved_cause = mcause_o;
            mepc_we_i = 1; mepc_wdata_i = 32'h0000_5A5B + r * 16;
            set_mstatus(r == 0 ? 32'h80 : 32'h08);
            mepc_we_i = 0;
            mret_i = 1;
            #1 chk("R9 no squash on return", {31'd0, squash_o}, 0);
            tick(); idle();
            chk("R7 valid", {31'd0, redir_valid_o}, 1);
            chk("R7 target", redir_pc_o, 32'h0000_5A5A + r * 16);
            chk("R7 mstatus", mstatus_o, r == 0 ? 32'h88 : 32'h80);
            chk("R7 cause held", mcause_o, saved_cause);
            chk("R7 mepc held", mepc_o, 32'h0000_5A5A + r * 16);
            tick();
        end

        // R8 trap and return together
        set_mstatus(32'h08);
        ex_valid_i = 1; exc_flags_i = 9'h040; ex_pc_i = 32'h6000; tvec_i = 32'hA000_0001;
        mret_i = 1;
        tick(); idle();
        chk("R8 cause", mcause_o, 3);
        chk("R8 target", redir_pc_o, 32'hA000_0000);
        chk("R8 mstatus", mstatus_o, 32'h80);
        tick();

        // R10 everything dropped during a redirect cycle
        ex_valid_i = 1; exc_flags_i = 9'h100; ex_pc_i = 32'h6100; tvec_i = 32'hB000_0000;
        tick();
        saved_cause = mcause_o; saved_pc = mepc_o; saved_st = mstatus_o;
        chk("R10 cause entered", saved_cause, 5);
        ex_valid_i = 1; exc_flags_i = 9'h001; irq_take_i = 1; irq_code_i = 11'd11;
        mret_i = 1; mstatus_we_i = 1; mstatus_wdata_i = 32'hFFFF_FFFF;
        mepc_we_i = 1; mepc_wdata_i = 32'h1111_1111;
        #1 chk("R10 no squash", {31'd0, squash_o}, 0);
        tick(); idle();
        chk("R10 no second redirect", {31'd0, redir_valid_o}, 0);
        chk("R10 cause", mcause_o, saved_cause);
        chk("R10 mepc", mepc_o, saved_pc);
        chk("R10 mstatus", mstatus_o, saved_st);

        // R11 software write masking and collision
        set_mstatus(32'hFFFF_FFFF);
        chk("R11 mstatus mask", mstatus_o, 32'h88);
        mepc_we_i = 1; mepc_wdata_i = 32'h0000_1235; tick(); mepc_we_i = 0;
        chk("R11 mepc bit0", mepc_o, 32'h0000_1234);
        ex_valid_i = 1; exc_flags_i = 9'h008; ex_pc_i = 32'h6200;
        mstatus_we_i = 1; mstatus_wdata_i = 32'h0;
        mepc_we_i = 1; mepc_wdata_i = 32'hDEAD_0000;
        tick(); idle();
        chk("R11 collide mstatus", mstatus_o, 32'h80);
        chk("R11 collide mepc", mepc_o, 32'h6200);
        chk("R2 illegal code", mcause_o, 2);
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule